// File: doc/BRIEF.md
# SD Host Command-Issue and Soft-Reset Control

This block is the register-side control unit of an SD card host. Software reaches it through a simple register bus: one write per cycle, with a combinational read port. Software stages a 32-bit command argument and then writes a command word whose top bit requests issue. While that start flag is set, the command is presented to the card-interface logic through a request/acknowledge handshake. The flag drops once the card interface accepts the command. Command serialisation, CRC and data transfer are not part of this block; only the acceptance handshake is modelled.

Three soft-reset bits cover the controller, the FIFO and the DMA engine. Software sets them, and each one clears itself after a fixed number of cycles. A command word can also be marked as a clock update. Such a command never raises the card-side request. It only copies the staged clock divider, source and enable settings into the active clock configuration.

Two rules protect command issue. Writing the command or argument register while a command is still pending sets a sticky locked error and is otherwise ignored. A data-write command aimed at a slot whose write-protect input is high is refused and sets a sticky refusal flag. Both flags are cleared by writing 1 to them.

Top module: `sd_host_ctl`

## Requirements
- R1: After reset, all readable registers read 0, `cif_req` is 0, `act_clkcfg` is 0 and all three reset outputs are 0.
- R2: Writing address 0 with bit 0 (controller), bit 1 (FIFO) or bit 2 (DMA) set raises the matching reset output after that edge. The output stays high for exactly 4 cycles and then clears by itself. Bits written as 0 have no effect.
- R3: A write to the command register (address 2) with bit 31 set, while no command is pending, sets the start flag (read back at bit 31 of address 2). If bit 10 is 0, `cif_req` is raised after that edge. The request and the start flag stay high until a cycle in which `cif_ack` is sampled high, and they are low from the next cycle.
- R4: `cif_arg` takes the value staged at address 1 at the moment the command is issued. Writes to address 1 after the command has completed do not change `cif_arg` until the next issue.
- R5: A command word with bit 10 set (clock update) never raises `cif_req`. In the cycle after issue, `act_clkcfg` takes the value staged at address 3 and the start flag clears. Writes to address 3 alone do not change `act_clkcfg`.
- R6: While the start flag is set, a write to address 1 or 2 sets the locked-error flag (address 4, bit 0) and leaves the staged argument and the pending command unchanged.
- R7: The two status flags at address 4 (bit 0 locked error, bit 1 write-protect refusal) are sticky. Writing 1 to a bit clears it.
- R8: A command with bit 6 (data expected) and bit 7 (write) both set, whose slot bit 8 selects a `wp_in` bit that is high, is not issued. The start flag stays 0 and status bit 1 is set. A command that only reads, or that targets an unprotected slot, is issued normally.
- R9: While a request is pending, `cif_index` shows command bits 5:0, `cif_data` bit 6, `cif_write` bit 7, `cif_slot` bit 8 and `cif_hold` (launch on the hold-delayed card clock) bit 9.
- R10: A command-register write with bit 31 clear issues nothing and leaves the command register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 reset control, 1 argument, 2 command, 3 staged clock, 4 status) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| wp_in | input | 2 | Write-protect level per slot, high means protected |
| cif_req | output | 1 | Command offered to the card interface |
| cif_ack | input | 1 | Card interface accepts the offered command |
| cif_arg | output | 32 | Captured command argument |
| cif_index | output | 6 | Command index |
| cif_data | output | 1 | Command expects a data phase |
| cif_write | output | 1 | Data phase writes to the card |
| cif_slot | output | 1 | Target slot |
| cif_hold | output | 1 | Launch outputs on the hold-delayed clock |
| act_clkcfg | output | 2*DIV_W+4 | Active clock configuration: two dividers, two source bits, two enable bits |
| rst_ctrl_o | output | 1 | Controller soft reset |
| rst_fifo_o | output | 1 | FIFO soft reset |
| rst_dma_o | output | 1 | DMA soft reset |

## Verification
The assertions take for granted that `wp_in` does not change between the command write and the following cycle, so the protection seen at issue is the one that was checked. They also take for granted that `cif_ack` only matters while `cif_req` is high. The stimulus changes `wp_in` only while no command is pending. It drives `cif_ack` for a single cycle during a request and never outside one, and it issues commands one at a time, waiting for each to complete or be refused.

// File: rtl/sd_host_ctl.sv
module sd_host_ctl #(
  parameter int RST_CYCLES = 4,
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [1:0]           wp_in,
  output logic                 cif_req,
  input  logic                 cif_ack,
  output logic [31:0]          cif_arg,
  output logic [5:0]           cif_index,
  output logic                 cif_data,
  output logic                 cif_write,
  output logic                 cif_slot,
  output logic                 cif_hold,
  output logic [2*DIV_W+3:0]   act_clkcfg,
  output logic                 rst_ctrl_o,
  output logic                 rst_fifo_o,
  output logic                 rst_dma_o
);
  localparam int CLK_W = 2*DIV_W+4;
  localparam int RC_W  = $clog2(RST_CYCLES+1);
  localparam logic [2:0] A_CTRL = 3'd0, A_ARG = 3'd1, A_CMD = 3'd2,
                         A_CLK = 3'd3, A_STAT = 3'd4;

  logic              start_q, hle_q, wpe_q;
  logic [10:0]       cmd_q;
  logic [31:0]       arg_stage, arg_act;
  logic [CLK_W-1:0]  clk_stage, clk_act;
  logic [2:0]        rst_q;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_arg   = reg_wr && reg_addr == A_ARG;
  wire wr_cmd   = reg_wr && reg_addr == A_CMD;
  wire wr_clk   = reg_wr && reg_addr == A_CLK;
  wire wr_stat  = reg_wr && reg_addr == A_STAT;
  wire new_cmd  = wr_cmd && reg_wdata[31] && !start_q;
  wire wp_block = reg_wdata[6] && reg_wdata[7] && wp_in[reg_wdata[8]];
  wire launch   = new_cmd && !wp_block;
  wire upd_done = start_q && cmd_q[10];

  assign cif_req    = start_q && !cmd_q[10];
  assign cif_arg    = arg_act;
  assign cif_index  = cmd_q[5:0];
  assign cif_data   = cmd_q[6];
  assign cif_write  = cmd_q[7];
  assign cif_slot   = cmd_q[8];
  assign cif_hold   = cmd_q[9];
  assign act_clkcfg = clk_act;
  assign rst_ctrl_o = rst_q[0];
  assign rst_fifo_o = rst_q[1];
  assign rst_dma_o  = rst_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      cmd_q     <= '0;
      arg_stage <= '0;
      arg_act   <= '0;
      clk_stage <= '0;
      clk_act   <= '0;
      hle_q     <= 1'b0;
      wpe_q     <= 1'b0;
    end else begin
      if (wr_arg && !start_q) arg_stage <= reg_wdata;
      if (wr_clk) clk_stage <= reg_wdata[CLK_W-1:0];
      if (launch) begin
        start_q <= 1'b1;
        cmd_q   <= reg_wdata[10:0];
        arg_act <= arg_stage;
      end else if ((cif_req && cif_ack) || upd_done) begin
        start_q <= 1'b0;
      end
      if (upd_done) clk_act <= clk_stage;
      if ((wr_cmd || wr_arg) && start_q) hle_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) hle_q <= 1'b0;
      if (new_cmd && wp_block) wpe_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) wpe_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_srst
    logic            on_q;
    logic [RC_W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else if (!on_q) begin
        if (wr_ctrl && reg_wdata[i]) begin
          on_q  <= 1'b1;
          cnt_q <= '0;
        end
      end else if (cnt_q == RC_W'(RST_CYCLES-1)) begin
        on_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign rst_q[i] = on_q;
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {29'd0, rst_q};
      A_ARG:   reg_rdata = arg_stage;
      A_CMD:   reg_rdata = {start_q, 20'd0, cmd_q};
      A_CLK:   reg_rdata = {{(32-CLK_W){1'b0}}, clk_stage};
      A_STAT:  reg_rdata = {30'd0, wpe_q, hle_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sd_host_ctl_chk.sv
module sd_host_ctl_chk #(
  parameter int RST_CYCLES = 4,
  parameter int DIV_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cif_req,
  input logic               cif_ack,
  input logic [31:0]        cif_arg,
  input logic [5:0]         cif_index,
  input logic               cif_data,
  input logic               cif_write,
  input logic               cif_slot,
  input logic [1:0]         wp_in,
  input logic [2*DIV_W+3:0] act_clkcfg,
  input logic               rst_ctrl_o
);
  int hc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc <= 0;
    else hc <= rst_ctrl_o ? hc + 1 : 0;
  end

  p_rst_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ctrl_o |-> hc < RST_CYCLES);
  p_rst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_ctrl_o) |-> $past(hc) == RST_CYCLES-1);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cif_req && !cif_ack |=> cif_req && $stable(cif_arg) && $stable(cif_index));
  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cif_req && cif_ack |=> !cif_req);
  p_clk_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_clkcfg) |-> !cif_req && !$past(cif_req));
  p_wp_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cif_req) |-> !(cif_data && cif_write && wp_in[cif_slot]));
endmodule

bind sd_host_ctl sd_host_ctl_chk #(.RST_CYCLES(RST_CYCLES), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/test_sd_host_ctl.sv
module test_sd_host_ctl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, cif_ack = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  wp_in = '0;
  logic [31:0] reg_rdata, cif_arg;
  logic [5:0]  cif_index;
  logic        cif_req, cif_data, cif_write, cif_slot, cif_hold;
  logic [19:0] act_clkcfg;
  logic        rst_ctrl_o, rst_fifo_o, rst_dma_o;
  int          tests = 0, fails = 0;

  always #4 clk = ~clk;

  sd_host_ctl i_sd_host_ctl (.*);

  // {issue, wp, cmd[10:0], arg}
  localparam logic [45:0] VEC [7] = '{
    {1'b1, 2'b00, 11'h051, 32'h0000_1234},
    {1'b1, 2'b00, 11'h3D8, 32'hDEAD_BEEF},
    {1'b0, 2'b10, 11'h3D8, 32'h1111_2222},
    {1'b1, 2'b10, 11'h0D9, 32'h3333_4444},
    {1'b0, 2'b01, 11'h0D9, 32'h5555_6666},
    {1'b1, 2'b10, 11'h152, 32'h7777_8888},
    {1'b1, 2'b11, 11'h300, 32'h9999_AAAA}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic ack1();
    cif_ack = 1'b1;
    @(negedge clk);
    cif_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reg", d, 0);
    end
    chk("R1 outs", {cif_req, act_clkcfg, rst_ctrl_o, rst_fifo_o, rst_dma_o}, 0);

    for (int i = 0; i < 7; i++) begin
      logic [45:0] v;
      v = VEC[i];
      wp_in = v[44:43];
      wr(3'd1, v[31:0]);
      wr(3'd2, {1'b1, 20'd0, v[42:32]});
      chk("R3/R8 issue", cif_req, v[45]);
      if (v[45]) begin
        chk("R9 fields", {cif_index, cif_data, cif_write, cif_slot, cif_hold},
            {v[37:32], v[38], v[39], v[40], v[41]});
        chk("R4 arg", cif_arg, v[31:0]);
        repeat (2) @(negedge clk);
        chk("R3 held", cif_req, 1);
        ack1();
        chk("R3 drop", cif_req, 0);
        rd(3'd2, d);
        chk("R3 start clr", d[31], 0);
      end else begin
        rd(3'd2, d);
        chk("R8 no start", d[31], 0);
        rd(3'd4, d);
        chk("R8 refuse flag", d[1:0], 2'b10);
        wr(3'd4, 32'h2);
        rd(3'd4, d);
        chk("R7 w1c", d[1:0], 0);
      end
    end
    wp_in = 2'b00;

    wr(3'd1, 32'hCAFE_0001);
    chk("R4 arg kept", cif_arg, 32'h9999_AAAA);

    wr(3'd2, {1'b1, 20'd0, 11'h005});
    wr(3'd1, 32'h0BAD_0BAD);
    wr(3'd2, {1'b1, 20'd0, 11'h03F});
    rd(3'd4, d);
    chk("R6 locked flag", d[0], 1);
    rd(3'd1, d);
    chk("R6 arg stage", d, 32'hCAFE_0001);
    chk("R6 pending", {cif_req, cif_index, cif_arg}, {1'b1, 6'h05, 32'hCAFE_0001});
    ack1();
    wr(3'd4, 32'h0);
    rd(3'd4, d);
    chk("R7 zero keeps", d[0], 1);
    wr(3'd4, 32'h1);
    rd(3'd4, d);
    chk("R7 w1c", d[0], 0);

    wr(3'd2, {1'b0, 20'd0, 11'h2AA});
    chk("R10 no req", cif_req, 0);
    rd(3'd2, d);
    chk("R10 cmd kept", d, 32'h0000_0005);

    wr(3'd3, 32'h000A_BCDE);
    chk("R5 stage only", act_clkcfg, 0);
    wr(3'd2, {1'b1, 20'd0, 11'h400});
    chk("R5 no req", cif_req, 0);
    rd(3'd2, d);
    chk("R5 start set", d[31], 1);
    @(negedge clk);
    chk("R5 copied", act_clkcfg, 20'hABCDE);
    chk("R5 no req after", cif_req, 0);
    rd(3'd2, d);
    chk("R5 start clr", d[31], 0);

    wr(3'd0, 32'h5);
    chk("R2 set", {rst_ctrl_o, rst_fifo_o, rst_dma_o}, 3'b101);
    repeat (3) @(negedge clk);
    chk("R2 4th cycle", {rst_ctrl_o, rst_dma_o}, 2'b11);
    @(negedge clk);
    chk("R2 cleared", {rst_ctrl_o, rst_fifo_o, rst_dma_o}, 3'b000);
    wr(3'd0, 32'h2);
    chk("R2 fifo only", {rst_ctrl_o, rst_fifo_o, rst_dma_o}, 3'b010);
    repeat (4) @(negedge clk);
    chk("R2 fifo cleared", rst_fifo_o, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule